// File: doc/BRIEF.md
# Video Memory Address Translator

This block forms the 15-bit DRAM byte address for a shared video and processor memory. Memory time is split into two slots by a 2 MHz phase signal. In the low half the processor owns the memory and its address goes through untouched. In the high half a video fetch is made. Bit 13 of the display controller's character address then chooses between two video layouts.

The bitmap layout builds the byte address from the character address and the three-bit scanline counter. When a fetch would run past the top of RAM, a wraparound corrector subtracts a whole number of 2 KB units from the upper nibble. This lets the screen start be moved for hardware scrolling. A two-bit screen-size code, held in an outside latch, picks how many units are subtracted.

The teletext layout confines fetches to one of two 1 KB windows and ignores the scanline counter. It inverts address bit 6 in one half of each 1 MHz period, so two bytes are read per microsecond and every DRAM row is visited on each scanline. A take strobe marks the fetch that the character generator keeps. When `REG_OUT` is set, an optional output register captures the address on each rising edge of the phase signal.

Top module: `vid_addr_xlat`

## Requirements
- R1: While `phase_2m` is 0, `dram_addr` equals `cpu_addr` bit for bit.
- R2: While `phase_2m` is 1, `char_addr[13]` = 1 selects the teletext layout and `char_addr[13]` = 0 selects the bitmap layout.
- R3: In the bitmap layout, `dram_addr[2:0]` = `row_addr` and `dram_addr[10:3]` = `char_addr[7:0]`.
- R4: In the bitmap layout with `char_addr[12]` = 0, `dram_addr[14:11]` = `char_addr[11:8]`.
- R5: In the bitmap layout with `char_addr[12]` = 1, `dram_addr[14:11]` = (`char_addr[11:8]` − N) mod 16. N is 8 for `size_code` 00, 4 for 01, 10 for 10 and 5 for 11. With `char_addr` = 0x1000 and `row_addr` = 0, the address is 0x4000, 0x6000, 0x3000 or 0x5800 in that code order.
- R6: In the teletext layout, `dram_addr[14]` = `char_addr[11]`, `dram_addr[13:10]` = 1111, `dram_addr[9:7]` = `char_addr[9:7]` and `dram_addr[5:0]` = `char_addr[5:0]`. `char_addr[10]`, `char_addr[12]`, `row_addr` and `size_code` have no effect.
- R7: In the teletext layout, `dram_addr[6]` = `char_addr[6]` XOR NOT `clk_1m`.
- R8: Character addresses 0x2400 to 0x27FF map to 0x3C00 to 0x3FFF, and 0x2800 to 0x2BFF map to 0x7C00 to 0x7FFF. A count run upward from 0x2400 therefore yields one continuous 2 KB stream.
- R9: `ttx_take` is 1 exactly when `phase_2m` = 1, `char_addr[13]` = 1 and `clk_1m` = 1.
- R10: With `REG_OUT` = 1, `dram_addr` loads the translated address on a `clk` edge where `phase_2m` is 1 and was 0 at the previous edge. It holds its value otherwise and is cleared to 0 by a synchronous active-low reset.

Here R7 and R9 together mean that the kept teletext fetch always carries the untouched bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register and the checks |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_2m | input | 1 | Slot phase: 0 = processor, 1 = video |
| clk_1m | input | 1 | 1 MHz clock driving the teletext double fetch |
| cpu_addr | input | 15 | Processor byte address |
| char_addr | input | 14 | Display controller character address |
| row_addr | input | 3 | Scanline counter within a character row |
| size_code | input | 2 | Screen-size code choosing the wrap amount |
| dram_addr | output | 15 | Translated DRAM byte address |
| ttx_take | output | 1 | Marks the teletext fetch passed to the character generator |

## Verification
The bench drives each size code with `char_addr` at 0x1000 and checks each restart address. A subtractor with a wrong unit count or a dropped carry would point the screen at the wrong block. It walks the 0x2400 teletext stream across the 0x27FF/0x2800 seam, where a design that decoded `char_addr[10]` would leave the 0x3C00 window. It compares bit 6 and the take strobe in both halves of `clk_1m`, which catches an inverted double-fetch phase. Random traffic exercises the registered stage with isolated and back-to-back phase rises, which catches a stage that loads on the level instead of the edge.

// File: rtl/vx_pkg.sv
// Shared widths, slot type and the wrap amount table of the translator.
// Assumes a 15-bit DRAM byte space, a 14-bit character address and a
// 3-bit scanline counter.
package vx_pkg;
    localparam int DA_W   = 15;
    localparam int MA_W   = 14;
    localparam int RA_W   = 3;
    localparam int NIB_W  = 4;
    localparam int LOW_W  = 8;                 // character bits placed above the row
    localparam int CODE_W = 2;
    localparam int TTX_LO = 10;                // teletext window bits kept from MA

    typedef enum logic [1:0] {
        SLOT_CPU    = 2'd0,
        SLOT_BITMAP = 2'd1,
        SLOT_TTX    = 2'd2
    } slot_e;

    // Number of 2 KB units removed when a bitmap fetch wraps.
    function automatic logic [NIB_W-1:0] wrap_units(input logic [CODE_W-1:0] code);
        logic [NIB_W-1:0] n;
        case (code)
            2'b00:   n = 4'd8;
            2'b01:   n = 4'd4;
            2'b10:   n = 4'd10;
            default: n = 4'd5;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/vx_slot_sel.sv
// Decodes the memory slot owner from the phase and character bit 13.
// Assumes phase high means a video slot.
module vx_slot_sel
    import vx_pkg::*;
(
    input  logic  phase_2m,
    input  logic  ma_top,
    output slot_e slot
);
    // Pick the owner of the current slot.
    always_comb begin
        if (!phase_2m)   slot = SLOT_CPU;
        else if (ma_top) slot = SLOT_TTX;
        else             slot = SLOT_BITMAP;
    end
endmodule

// File: rtl/vx_wrap.sv
// Wraparound corrector: a 4-bit adder that adds the complement of the
// unit count (that is, 16 - N) when the wrap bit is set.
// Assumes the result is used modulo 16.
module vx_wrap
    import vx_pkg::*;
(
    input  logic [NIB_W-1:0]  nib_in,
    input  logic              wrap_en,
    input  logic [CODE_W-1:0] size_code,
    output logic [NIB_W-1:0]  nib_out
);
    logic [NIB_W-1:0] addend;

    // Gate the complemented unit count onto the adder's second input.
    always_comb begin
        addend = wrap_en ? ~(wrap_units(size_code) - 4'd1) : '0;
    end

    // Four-bit add; the carry out is dropped.
    always_comb begin
        nib_out = nib_in + addend;
    end
endmodule

// File: rtl/vx_bitmap.sv
// Bitmap layout: the row counter goes in the low bits, then eight
// character bits, then the corrected upper nibble. Assumes MA13 is
// already decoded elsewhere.
module vx_bitmap
    import vx_pkg::*;
(
    input  logic [MA_W-1:0]   ma,
    input  logic [RA_W-1:0]   ra,
    input  logic [CODE_W-1:0] size_code,
    output logic [DA_W-1:0]   da
);
    logic [NIB_W-1:0] nib_fix;

    vx_wrap u_wrap (
        .nib_in   (ma[LOW_W+NIB_W-1:LOW_W]),
        .wrap_en  (ma[LOW_W+NIB_W]),
        .size_code(size_code),
        .nib_out  (nib_fix)
    );

    // Place the three fields into the byte address.
    always_comb begin
        da = {nib_fix, ma[LOW_W-1:0], ra};
    end
endmodule

// File: rtl/vx_ttx.sv
// Teletext layout: a fixed 1 KB window chosen by MA11, with bit 6
// toggled by the 1 MHz clock for the double fetch. Assumes clk_1m high
// marks the fetch that is kept.
module vx_ttx
    import vx_pkg::*;
(
    input  logic [MA_W-1:0] ma,
    input  logic            clk_1m,
    output logic [DA_W-1:0] da,
    output logic            keep
);
    // Build the window address; MA10, MA12 and the row are unused.
    always_comb begin
        da        = '0;
        da[14]    = ma[11];
        da[13:10] = 4'hF;
        da[9:7]   = ma[9:7];
        da[6]     = ma[6] ^ ~clk_1m;
        da[5:0]   = ma[5:0];
    end

    // The kept fetch is the one that carries the untouched bit 6.
    always_comb begin
        keep = clk_1m;
    end
endmodule

// File: rtl/vx_out_reg.sv
// Optional output stage: captures the address when the phase input
// rises, sampled on clk. Assumes clk is much faster than the phase.
module vx_out_reg #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic phase_q;
    logic rise;

    // Detect the rising phase from the previous sample.
    always_comb begin
        rise = phase && !phase_q;
    end

    // Remember the phase and capture the address on a rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            q       <= '0;
        end else begin
            phase_q <= phase;
            if (rise) q <= d;
        end
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(q));
    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> q == $past(d));
endmodule

// File: rtl/vid_addr_xlat.sv
// Top of the video memory address translator. It selects the processor,
// bitmap or teletext address for each slot, with an optional registered
// output. Assumes all inputs are stable around the clk edge.
module vid_addr_xlat
    import vx_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_2m,
    input  logic              clk_1m,
    input  logic [DA_W-1:0]   cpu_addr,
    input  logic [MA_W-1:0]   char_addr,
    input  logic [RA_W-1:0]   row_addr,
    input  logic [CODE_W-1:0] size_code,
    output logic [DA_W-1:0]   dram_addr,
    output logic              ttx_take
);
    slot_e           slot;
    logic [DA_W-1:0] da_bmp;
    logic [DA_W-1:0] da_ttx;
    logic [DA_W-1:0] da_mux;
    logic            ttx_keep;

    vx_slot_sel u_sel (
        .phase_2m(phase_2m),
        .ma_top  (char_addr[MA_W-1]),
        .slot    (slot)
    );

    vx_bitmap u_bmp (
        .ma       (char_addr),
        .ra       (row_addr),
        .size_code(size_code),
        .da       (da_bmp)
    );

    vx_ttx u_ttx (
        .ma    (char_addr),
        .clk_1m(clk_1m),
        .da    (da_ttx),
        .keep  (ttx_keep)
    );

    // Route the address of the slot owner.
    always_comb begin
        case (slot)
            SLOT_BITMAP: da_mux = da_bmp;
            SLOT_TTX:    da_mux = da_ttx;
            default:     da_mux = cpu_addr;
        endcase
    end

    // The take strobe is only meaningful in a teletext slot.
    always_comb begin
        ttx_take = (slot == SLOT_TTX) && ttx_keep;
    end

    generate
        if (REG_OUT) begin : g_reg
            vx_out_reg #(.W(DA_W)) u_oreg (
                .clk  (clk),
                .rst_n(rst_n),
                .phase(phase_2m),
                .d    (da_mux),
                .q    (dram_addr)
            );
        end else begin : g_comb
            assign dram_addr = da_mux;
        end
    endgenerate

    a_r1_cpu_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_2m |-> da_mux == cpu_addr);
    a_r3_bitmap_row: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_2m && !char_addr[13]) |-> da_mux[2:0] == row_addr);
    a_r6_ttx_window: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_2m && char_addr[13]) |-> da_mux[13:10] == 4'hF);
    a_r9_take_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ttx_take |-> (phase_2m && char_addr[13] && clk_1m));
    a_r7_kept_bit6: assert property (@(posedge clk) disable iff (!rst_n)
        ttx_take |-> da_mux[6] == char_addr[6]);
endmodule

// File: tb/vid_addr_xlat_test.sv
// Bench: a behavioural reference model compared on every clock against a
// combinational instance (uut) and a registered instance (uut_reg).
module vid_addr_xlat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_2m = 1'b0;
    logic        clk_1m = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic [13:0] char_addr = '0;
    logic [2:0]  row_addr = '0;
    logic [1:0]  size_code = '0;
    logic [14:0] da_c, da_r;
    logic        take_c, take_r;

    int checks = 0;
    int errors = 0;
    int exp_q = 0;
    bit ph_prev = 1'b0;

    always #2 clk = ~clk;

    vid_addr_xlat #(.REG_OUT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .phase_2m(phase_2m), .clk_1m(clk_1m),
        .cpu_addr(cpu_addr), .char_addr(char_addr), .row_addr(row_addr),
        .size_code(size_code), .dram_addr(da_c), .ttx_take(take_c));

    vid_addr_xlat #(.REG_OUT(1'b1)) uut_reg (
        .clk(clk), .rst_n(rst_n), .phase_2m(phase_2m), .clk_1m(clk_1m),
        .cpu_addr(cpu_addr), .char_addr(char_addr), .row_addr(row_addr),
        .size_code(size_code), .dram_addr(da_r), .ttx_take(take_r));

    // Reference: byte arithmetic straight from the requirements.
    function automatic int ref_da(int ph, int c1m, int cpu, int ma, int ra, int code);
        int a, amt;
        if (ph == 0) return cpu;                       // R1
        if (((ma >> 13) & 1) == 1) begin               // R2 teletext
            a = ((ma & 'h800) << 3) | 'h3C00 | (ma & 'h3FF);  // R6, R8
            if (c1m == 0) a = a ^ 'h40;                // R7
            return a;
        end
        a = ((ma & 'hFFF) << 3) | (ra & 7);            // R3, R4
        if (((ma >> 12) & 1) == 1) begin               // R5
            case (code)
                0: amt = 'h4000;
                1: amt = 'h2000;
                2: amt = 'h5000;
                default: amt = 'h2800;
            endcase
            a = (a + 'h8000 - amt) & 'h7FFF;
        end
        return a;
    endfunction

    function automatic string tag_of(int ph, int ma);
        if (ph == 0) return "R1";
        if (((ma >> 13) & 1) == 1) return "R6";
        if (((ma >> 12) & 1) == 1) return "R5";
        return "R4";
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model of the registered stage (R10), updated at each clk edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q   = 0;
            ph_prev = 1'b0;
        end else begin
            if (phase_2m && !ph_prev)
                exp_q = ref_da(phase_2m, clk_1m, cpu_addr, char_addr, row_addr, size_code);
            ph_prev = phase_2m;
        end
    end

    // Apply one input set at the falling edge, then compare everything.
    task automatic step(input string tag, input bit ph, input bit c1m, input int cpu,
                        input int ma, input int ra, input int code);
        @(negedge clk);
        check("R10", da_r, exp_q);
        phase_2m  = ph;
        clk_1m    = c1m;
        cpu_addr  = cpu[14:0];
        char_addr = ma[13:0];
        row_addr  = ra[2:0];
        size_code = code[1:0];
        #1;
        check(tag, da_c, ref_da(ph, c1m, cpu, ma, ra, code));
        check("R9", take_c, (ph && ma[13] && c1m) ? 1 : 0);
    endtask

    initial begin
        #40000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10", da_r, 0);                 // reset clears the register
        rst_n = 1'b1;
        // R1 passthrough
        step("R1", 0, 1, 'h7ABC, 'h3FFF, 7, 3);
        // R2: the same address in both layouts
        step("R2", 1, 1, 0, 'h0123, 5, 0);
        step("R2", 1, 1, 0, 'h2123, 5, 0);
        // R3 and R4: no wrap
        step("R3", 1, 0, 0, 'h0FFF, 6, 2);
        // R5 restart addresses for each size code
        for (int c = 0; c < 4; c++) begin
            step("R5", 0, 0, 0, 0, 0, 0);
            step("R5", 1, 0, 0, 'h1000, 0, c);
        end
        // R7 both halves of the 1 MHz period
        step("R7", 1, 0, 0, 'h2040, 3, 1);
        step("R7", 1, 1, 0, 'h2040, 3, 1);
        // R6: MA10, MA12, row and code ignored
        step("R6", 1, 1, 0, 'h3555, 7, 2);
        // R8 stream across the seam
        for (int m = 'h23FE; m < 'h2404; m++) step("R8", 1, 1, 0, m, 0, 0);
        for (int m = 'h27FE; m < 'h2802; m++) step("R8", 1, 1, 0, m, 0, 0);
        // Random traffic with frequent phase changes
        for (int i = 0; i < 3000; i++) begin
            int ph, ma;
            ph = $urandom_range(0, 1);
            ma = $urandom_range(0, 'h3FFF);
            step(tag_of(ph, ma), ph[0], $urandom_range(0, 1), $urandom_range(0, 'h7FFF),
                 ma, $urandom_range(0, 7), $urandom_range(0, 3));
        end
        // Reset again mid-run (R10)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", da_r, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule